// File: doc/BRIEF.md
# Software-Refilled Address Translation Buffer

This block is a small fully associative cache of page translations. A lookup names a 32-bit virtual address, whether it is a read or a write, and whether the access comes from user or supervisor mode. One clock later the block either reports a hit with the physical address, or pulses a fault carrying the virtual address and a cause code. There is no hardware table walker. Every miss, every match on an entry marked not-valid and every permission violation is handed to software. Software then installs the translation through a load port and retries.

Software owns the contents of every slot. It can write a slot at an index it chooses, or at a pseudo-random victim index that the block offers. It can clear one slot's valid bit or all of them at once. It can read back any slot, including the referenced and modified bits that the hardware keeps up to date, so that they can be copied into the page tables before the slot is reused.

The page offset is the low 12 bits of the address and passes through unchanged. The page number is the upper 20 bits. It is compared against every stored tag in parallel.

Top module: `tlb_xlate`

## Requirements
- R1: A lookup whose page number matches a slot with its valid bit set, and which passes the permission checks, gives `lk_hit`=1 in the cycle after the request. `lk_paddr` then equals the slot's frame number concatenated with the request's offset, and `flt_valid` stays 0.
- R2: A lookup whose page number matches no slot gives `flt_valid`=1 with `flt_cause`=0 in the following cycle. `flt_vaddr` equals the requested virtual address.
- R3: A lookup that matches a slot whose valid bit is 0 faults with `flt_cause`=1.
- R4: A write to a slot whose writable bit is 0, or a user-mode access to a slot whose user bit is 0, faults with `flt_cause`=2. A supervisor access ignores the user bit.
- R5: Bits [11:0] of the physical address equal bits [11:0] of the virtual address, and a page number may be placed in any slot.
- R6: A translated lookup sets the matched slot's referenced bit. A faulting lookup leaves it unchanged. A load clears the referenced and modified bits. Both bits are visible on the readback port.
- R7: A translated write sets the matched slot's modified bit. A translated read does not.
- R8: A load with `sw_rand`=1 writes the slot shown on `victim_idx` in that cycle. A load with `sw_rand`=0 writes slot `sw_idx`. `victim_idx` changes from cycle to cycle.
- R9: Each lookup produces exactly one of hit or fault, for one cycle only. Without a request, both outputs are 0.
- R10: `sw_inval` clears the valid bit of slot `sw_idx`. `sw_inval_all` clears every valid bit in one cycle and takes precedence over a load in the same cycle.
- R11: When several slots hold the same tag, the lowest-indexed one decides the result, even if that slot is not valid.
- R12: After reset every slot reads back all zero, and neither `lk_hit` nor `flt_valid` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | 1 = write access, 0 = read |
| lk_user | input | 1 | 1 = user-mode access |
| lk_hit | output | 1 | Translation succeeded (one cycle after request) |
| lk_paddr | output | 32 | Physical address, valid with lk_hit |
| flt_valid | output | 1 | One-cycle fault pulse |
| flt_vaddr | output | 32 | Faulting virtual address |
| flt_cause | output | 2 | 0 miss, 1 not valid, 2 protection |
| sw_load | input | 1 | Write a slot |
| sw_rand | input | 1 | Use victim_idx instead of sw_idx for the load |
| sw_idx | input | 3 | Slot index for load or single invalidate |
| sw_tag | input | 20 | Page number to store |
| sw_pfn | input | 20 | Frame number to store |
| sw_valid | input | 1 | Valid bit to store |
| sw_writable | input | 1 | Writable bit to store |
| sw_user | input | 1 | User-access bit to store |
| sw_inval | input | 1 | Clear the valid bit of slot sw_idx |
| sw_inval_all | input | 1 | Clear every valid bit |
| victim_idx | output | 3 | Current pseudo-random replacement slot |
| rd_idx | input | 3 | Readback slot index |
| rd_tag | output | 20 | Stored page number |
| rd_pfn | output | 20 | Stored frame number |
| rd_valid | output | 1 | Stored valid bit |
| rd_writable | output | 1 | Stored writable bit |
| rd_user | output | 1 | Stored user bit |
| rd_use | output | 1 | Referenced bit |
| rd_dirty | output | 1 | Modified bit |

## Verification
The assertions watch, on every cycle, that a hit and a fault never coincide and that either one follows a request. They also check that a hit keeps the request's page offset and that a fault reports the requested address with a legal cause. A further assertion checks that the cycle after a global invalidate shows no valid slot. Which slot wins among duplicate tags, which cause code applies, and how the referenced and modified bits evolve can only be shown by the bench. Its scenarios compare every result and readback against a reference model of the slots. The same holds for placement at the random victim index.

// File: rtl/tlb_pkg.sv
// Shared definitions for the translation buffer.
// Assumes a 2-bit fault cause field, decoded by the trap handler.
package tlb_pkg;
    typedef enum logic [1:0] {
        CAUSE_MISS    = 2'd0,
        CAUSE_INVALID = 2'd1,
        CAUSE_PROT    = 2'd2
    } flt_cause_e;
endpackage

// File: rtl/tlb_victim_lfsr.sv
// Free-running 16-bit maximal-length LFSR that is folded down to a slot index.
// Assumes ENTRIES >= 2. When ENTRIES is not a power of two, the folded value
// is brought back into range by one conditional subtraction.
module tlb_victim_lfsr #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [IDX_W-1:0] victim_idx
);
    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] SEED = 16'hACE1;

    logic [LFSR_W-1:0] lfsr_q;
    logic [IDX_W-1:0]  fold;

    // Step the shift register every cycle (taps 16,14,13,11).
    always_ff @(posedge clk) begin
        if (!rst_n) lfsr_q <= SEED;
        else        lfsr_q <= {lfsr_q[LFSR_W-2:0],
                               lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10]};
    end

    // XOR-fold all state bits into an index-wide value.
    always_comb begin
        fold = '0;
        for (int j = 0; j < LFSR_W; j++) fold[j % IDX_W] ^= lfsr_q[j];
    end

    generate
        if (ENTRIES == (1 << IDX_W)) begin : g_pow2
            assign victim_idx = fold;
        end else begin : g_wrap
            assign victim_idx = (fold >= IDX_W'(ENTRIES)) ? fold - IDX_W'(ENTRIES) : fold;
        end
    endgenerate
endmodule

// File: rtl/tlb_cam_match.sv
// Parallel tag compare across all slots with a lowest-index priority pick.
// Valid bits are not considered here, so a not-valid slot can still win.
module tlb_cam_match #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]              look_tag,
    output logic                          any_match,
    output logic [IDX_W-1:0]              match_idx
);
    logic [ENTRIES-1:0] eq;

    generate
        for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
            assign eq[i] = (tags[i] == look_tag);
        end
    endgenerate

    // Scan from the top down so that the lowest matching index is kept.
    always_comb begin
        match_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (eq[i]) match_idx = IDX_W'(i);
        end
    end

    assign any_match = |eq;
endmodule

// File: rtl/tlb_entry_store.sv
// Register storage for every slot: tag, frame, permission bits and the
// referenced/modified status. Precedence per slot: global invalidate clears
// valid; otherwise a load replaces the slot; otherwise a single invalidate
// and a lookup status update may both apply.
module tlb_entry_store #(
    parameter int ENTRIES = 8,
    parameter int TAG_W   = 20,
    parameter int PFN_W   = 20,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [IDX_W-1:0]              wr_idx,
    input  logic [TAG_W-1:0]              wr_tag,
    input  logic [PFN_W-1:0]              wr_pfn,
    input  logic                          wr_valid,
    input  logic                          wr_writable,
    input  logic                          wr_user,
    input  logic                          inv_en,
    input  logic [IDX_W-1:0]              inv_idx,
    input  logic                          inv_all,
    input  logic                          upd_en,
    input  logic [IDX_W-1:0]              upd_idx,
    input  logic                          upd_dirty,
    output logic [ENTRIES-1:0][TAG_W-1:0] tag_a,
    output logic [ENTRIES-1:0][PFN_W-1:0] pfn_a,
    output logic [ENTRIES-1:0]            valid_a,
    output logic [ENTRIES-1:0]            wr_a,
    output logic [ENTRIES-1:0]            usr_a,
    output logic [ENTRIES-1:0]            use_a,
    output logic [ENTRIES-1:0]            dirty_a
);
    generate
        for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
            logic sel_wr, sel_inv, sel_upd;
            assign sel_wr  = wr_en  && (wr_idx  == IDX_W'(i));
            assign sel_inv = inv_en && (inv_idx == IDX_W'(i));
            assign sel_upd = upd_en && (upd_idx == IDX_W'(i));

            // Hold and update one slot.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    tag_a[i]   <= '0;
                    pfn_a[i]   <= '0;
                    valid_a[i] <= 1'b0;
                    wr_a[i]    <= 1'b0;
                    usr_a[i]   <= 1'b0;
                    use_a[i]   <= 1'b0;
                    dirty_a[i] <= 1'b0;
                end else if (sel_wr) begin
                    tag_a[i]   <= wr_tag;
                    pfn_a[i]   <= wr_pfn;
                    valid_a[i] <= wr_valid && !inv_all;
                    wr_a[i]    <= wr_writable;
                    usr_a[i]   <= wr_user;
                    use_a[i]   <= 1'b0;
                    dirty_a[i] <= 1'b0;
                end else begin
                    if (inv_all || sel_inv) valid_a[i] <= 1'b0;
                    if (sel_upd) begin
                        use_a[i] <= 1'b1;
                        if (upd_dirty) dirty_a[i] <= 1'b1;
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/tlb_xlate.sv
// Top of the software-refilled translation buffer. A lookup is resolved
// combinationally against the current slots and registered, so hit or fault
// appears one cycle after the request. Any failure becomes a fault for
// software; no walker exists. Assumes at most one lookup per cycle.
module tlb_xlate #(
    parameter int VA_W    = 32,
    parameter int OFF_W   = 12,
    parameter int PFN_W   = 20,
    parameter int ENTRIES = 8,
    localparam int TAG_W  = VA_W - OFF_W,
    localparam int PA_W   = PFN_W + OFF_W,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_req,
    input  logic [VA_W-1:0]  lk_vaddr,
    input  logic             lk_write,
    input  logic             lk_user,
    output logic             lk_hit,
    output logic [PA_W-1:0]  lk_paddr,
    output logic             flt_valid,
    output logic [VA_W-1:0]  flt_vaddr,
    output logic [1:0]       flt_cause,
    input  logic             sw_load,
    input  logic             sw_rand,
    input  logic [IDX_W-1:0] sw_idx,
    input  logic [TAG_W-1:0] sw_tag,
    input  logic [PFN_W-1:0] sw_pfn,
    input  logic             sw_valid,
    input  logic             sw_writable,
    input  logic             sw_user,
    input  logic             sw_inval,
    input  logic             sw_inval_all,
    output logic [IDX_W-1:0] victim_idx,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic [PFN_W-1:0] rd_pfn,
    output logic             rd_valid,
    output logic             rd_writable,
    output logic             rd_user,
    output logic             rd_use,
    output logic             rd_dirty
);
    import tlb_pkg::*;

    logic [ENTRIES-1:0][TAG_W-1:0] tag_a;
    logic [ENTRIES-1:0][PFN_W-1:0] pfn_a;
    logic [ENTRIES-1:0]            valid_a, wr_a, usr_a, use_a, dirty_a;
    logic                          any_match;
    logic [IDX_W-1:0]              m_idx, load_idx;
    logic                          prot_bad, xl_ok, xl_fault;
    flt_cause_e                    cause_d;

    tlb_victim_lfsr #(.ENTRIES(ENTRIES)) u_victim (
        .clk(clk), .rst_n(rst_n), .victim_idx(victim_idx)
    );

    tlb_cam_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_match (
        .tags(tag_a), .look_tag(lk_vaddr[VA_W-1:OFF_W]),
        .any_match(any_match), .match_idx(m_idx)
    );

    assign load_idx = sw_rand ? victim_idx : sw_idx;

    tlb_entry_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .PFN_W(PFN_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_en(sw_load), .wr_idx(load_idx), .wr_tag(sw_tag), .wr_pfn(sw_pfn),
        .wr_valid(sw_valid), .wr_writable(sw_writable), .wr_user(sw_user),
        .inv_en(sw_inval), .inv_idx(sw_idx), .inv_all(sw_inval_all),
        .upd_en(xl_ok), .upd_idx(m_idx), .upd_dirty(lk_write),
        .tag_a(tag_a), .pfn_a(pfn_a), .valid_a(valid_a), .wr_a(wr_a),
        .usr_a(usr_a), .use_a(use_a), .dirty_a(dirty_a)
    );

    // Classify the lookup: permission, success and fault cause.
    always_comb begin
        prot_bad = (lk_write && !wr_a[m_idx]) || (lk_user && !usr_a[m_idx]);
        if (!any_match)          cause_d = CAUSE_MISS;
        else if (!valid_a[m_idx]) cause_d = CAUSE_INVALID;
        else                     cause_d = CAUSE_PROT;
        xl_ok    = lk_req && any_match && valid_a[m_idx] && !prot_bad;
        xl_fault = lk_req && !xl_ok;
    end

    // Register the lookup result and the fault pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_hit    <= 1'b0;
            lk_paddr  <= '0;
            flt_valid <= 1'b0;
            flt_vaddr <= '0;
            flt_cause <= 2'd0;
        end else begin
            lk_hit    <= xl_ok;
            lk_paddr  <= xl_ok ? {pfn_a[m_idx], lk_vaddr[OFF_W-1:0]} : '0;
            flt_valid <= xl_fault;
            flt_vaddr <= xl_fault ? lk_vaddr : '0;
            flt_cause <= xl_fault ? cause_d : 2'd0;
        end
    end

    // Readback of one slot for software.
    always_comb begin
        rd_tag      = tag_a[rd_idx];
        rd_pfn      = pfn_a[rd_idx];
        rd_valid    = valid_a[rd_idx];
        rd_writable = wr_a[rd_idx];
        rd_user     = usr_a[rd_idx];
        rd_use      = use_a[rd_idx];
        rd_dirty    = dirty_a[rd_idx];
    end
endmodule

// File: rtl/tlb_xlate_checker.sv
// Cycle-level properties of the translation buffer's ports, bound to the top.
module tlb_xlate_checker #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_req,
    input logic [VA_W-1:0]  lk_vaddr,
    input logic             lk_hit,
    input logic [OFF_W-1:0] pa_off,
    input logic             flt_valid,
    input logic [VA_W-1:0]  flt_vaddr,
    input logic [1:0]       flt_cause,
    input logic             sw_inval_all,
    input logic             rd_valid
);
    a_r9_hit_xor_fault: assert property (@(posedge clk) disable iff (!rst_n)
        !(lk_hit && flt_valid));
    a_r9_result_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_hit || flt_valid) |-> $past(lk_req));
    a_r9_fault_single: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid && !lk_req |=> !flt_valid);
    a_r5_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> pa_off == $past(lk_vaddr[OFF_W-1:0]));
    a_r2_fault_addr: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> flt_vaddr == $past(lk_vaddr));
    a_r4_cause_legal: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> flt_cause != 2'd3);
    a_r10_all_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        $past(sw_inval_all) |-> !rd_valid);
endmodule

bind tlb_xlate tlb_xlate_checker #(.VA_W(VA_W), .OFF_W(OFF_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr),
    .lk_hit(lk_hit), .pa_off(lk_paddr[OFF_W-1:0]), .flt_valid(flt_valid),
    .flt_vaddr(flt_vaddr), .flt_cause(flt_cause),
    .sw_inval_all(sw_inval_all), .rd_valid(rd_valid)
);

// File: tb/tlb_xlate_bench.sv
// Self-checking bench: directed corner cases then a seeded random mix,
// compared against a slot-level reference model.
module tlb_xlate_bench;
    localparam int CLK_PERIOD = 10;
    localparam int N = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lk_req = 0, lk_write = 0, lk_user = 0;
    logic [31:0] lk_vaddr = '0;
    logic lk_hit, flt_valid;
    logic [31:0] lk_paddr, flt_vaddr;
    logic [1:0] flt_cause;
    logic sw_load = 0, sw_rand = 0, sw_valid = 0, sw_writable = 0, sw_user = 0;
    logic sw_inval = 0, sw_inval_all = 0;
    logic [2:0] sw_idx = '0, rd_idx = '0, victim_idx;
    logic [19:0] sw_tag = '0, sw_pfn = '0, rd_tag, rd_pfn;
    logic rd_valid, rd_writable, rd_user, rd_use, rd_dirty;

    logic [19:0] m_tag [N];
    logic [19:0] m_pfn [N];
    bit m_v [N], m_w [N], m_u [N], m_use [N], m_dirty [N];
    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_xlate u_tlb_xlate (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int find(input logic [19:0] t);
        for (int i = 0; i < N; i++) if (m_tag[i] == t) return i;
        return -1;
    endfunction

    task automatic check_entry(input int idx, input string req);
        rd_idx = 3'(idx); #1;
        chk(rd_valid == m_v[idx], req, "rd_valid", rd_valid, m_v[idx]);
        chk(rd_use == m_use[idx], req, "rd_use", rd_use, m_use[idx]);
        chk(rd_dirty == m_dirty[idx], req, "rd_dirty", rd_dirty, m_dirty[idx]);
        chk(rd_tag == m_tag[idx] && rd_pfn == m_pfn[idx], req, "rd_tag/pfn",
            {rd_tag, rd_pfn}, {m_tag[idx], m_pfn[idx]});
        chk(rd_writable == m_w[idx] && rd_user == m_u[idx], req, "rd_perm",
            {rd_writable, rd_user}, {m_w[idx], m_u[idx]});
    endtask

    task automatic do_lookup(input logic [31:0] va, input bit wr, input bit usr,
                             input string req);
        int idx; bit eh; logic [1:0] ec;
        idx = find(va[31:12]); eh = 0; ec = 2'd0;
        if (idx < 0) ec = 2'd0;
        else if (!m_v[idx]) ec = 2'd1;
        else if ((wr && !m_w[idx]) || (usr && !m_u[idx])) ec = 2'd2;
        else eh = 1;
        lk_req = 1; lk_vaddr = va; lk_write = wr; lk_user = usr;
        @(posedge clk); #1;
        lk_req = 0;
        chk(lk_hit == eh, req, "lk_hit", lk_hit, eh);
        chk(flt_valid == !eh, req, "flt_valid", flt_valid, !eh);
        if (eh) begin
            chk(lk_paddr == {m_pfn[idx], va[11:0]}, req, "lk_paddr", lk_paddr,
                {m_pfn[idx], va[11:0]});
            m_use[idx] = 1;
            if (wr) m_dirty[idx] = 1;
        end else begin
            chk(flt_cause == ec, req, "flt_cause", flt_cause, ec);
            chk(flt_vaddr == va, req, "flt_vaddr", flt_vaddr, va);
        end
    endtask

    task automatic do_idle(input string req);
        @(posedge clk); #1;
        chk(!lk_hit && !flt_valid, req, "idle outputs", {lk_hit, flt_valid}, 2'b00);
    endtask

    task automatic do_load(input int idx, input bit rnd, input logic [19:0] t,
                           input logic [19:0] p, input bit v, input bit w,
                           input bit u, input bit all, output int tgt);
        sw_load = 1; sw_rand = rnd; sw_idx = 3'(idx); sw_tag = t; sw_pfn = p;
        sw_valid = v; sw_writable = w; sw_user = u; sw_inval_all = all;
        #1;
        tgt = rnd ? int'(victim_idx) : idx;
        @(posedge clk); #1;
        sw_load = 0; sw_rand = 0; sw_inval_all = 0;
        m_tag[tgt] = t; m_pfn[tgt] = p; m_v[tgt] = v; m_w[tgt] = w; m_u[tgt] = u;
        m_use[tgt] = 0; m_dirty[tgt] = 0;
        if (all) for (int i = 0; i < N; i++) m_v[i] = 0;
    endtask

    task automatic do_inval(input int idx, input bit all);
        sw_inval = !all; sw_inval_all = all; sw_idx = 3'(idx);
        @(posedge clk); #1;
        sw_inval = 0; sw_inval_all = 0;
        if (all) for (int i = 0; i < N; i++) m_v[i] = 0;
        else m_v[idx] = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R9 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int tgt, seed, first_v;
        bit varied;
        logic [19:0] pool [6];
        for (int i = 0; i < N; i++) begin
            m_tag[i] = '0; m_pfn[i] = '0; m_v[i] = 0; m_w[i] = 0; m_u[i] = 0;
            m_use[i] = 0; m_dirty[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R12: reset state
        chk(!lk_hit && !flt_valid, "R12", "outputs after reset", {lk_hit, flt_valid}, 0);
        for (int i = 0; i < N; i++) check_entry(i, "R12");

        // R12 leaves tag 0 in all slots: tag 0 lookup hits slot 0 not-valid (R3)
        do_lookup(32'h0000_0abc, 0, 0, "R3");
        // R2: miss
        do_lookup(32'h7777_7123, 0, 1, "R2");
        do_idle("R9");

        // R1/R5/R6/R7: valid translation in slot 3
        do_load(3, 0, 20'h12345, 20'hABCDE, 1, 1, 1, 0, tgt);
        do_lookup(32'h1234_5fed, 0, 1, "R1");
        check_entry(3, "R6");
        chk(!rd_dirty, "R7", "read leaves dirty", rd_dirty, 0);
        do_lookup(32'h1234_5001, 1, 0, "R5");
        check_entry(3, "R7");
        do_idle("R9");

        // R3: not-valid slot
        do_load(0, 0, 20'h00777, 20'h00042, 0, 1, 1, 0, tgt);
        do_lookup(32'h0077_7000, 0, 0, "R3");

        // R4: protection, then supervisor read allowed
        do_load(5, 0, 20'h00888, 20'h0BEEF, 1, 0, 0, 0, tgt);
        do_lookup(32'h0088_8010, 1, 0, "R4");
        do_lookup(32'h0088_8020, 0, 1, "R4");
        check_entry(5, "R6");
        do_lookup(32'h0088_8030, 0, 0, "R4");
        check_entry(5, "R6");

        // R11: duplicate tags, lowest index wins
        do_load(6, 0, 20'h00999, 20'h00001, 1, 1, 1, 0, tgt);
        do_load(7, 0, 20'h00999, 20'h00002, 1, 1, 1, 0, tgt);
        do_lookup(32'h0099_9abc, 0, 0, "R11");
        do_inval(6, 0);
        check_entry(6, "R10");
        do_lookup(32'h0099_9abc, 0, 0, "R11");

        // R8: random placement
        varied = 0; first_v = -1;
        for (int k = 0; k < 8; k++) begin
            do_load(0, 1, 20'h40000 + 20'(k), 20'h50000 + 20'(k), 1, 1, 1, 0, tgt);
            check_entry(tgt, "R8");
            if (first_v < 0) first_v = tgt; else if (tgt != first_v) varied = 1;
        end
        chk(varied, "R8", "victim varies", varied, 1);

        // R10: invalidate-all wins over a load in the same cycle
        do_load(2, 0, 20'h0ABCD, 20'h00123, 1, 1, 1, 1, tgt);
        for (int i = 0; i < N; i++) check_entry(i, "R10");
        do_lookup(32'h0ABC_D000, 0, 0, "R10");

        // Seeded random mix
        seed = 32'h5EED;
        void'($urandom(seed));
        for (int i = 0; i < 6; i++) pool[i] = 20'h10 + 20'(i);
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom % 100);
            if (op < 60) begin
                logic [31:0] va;
                va = {($urandom % 8 == 0) ? 20'($urandom) : pool[$urandom % 6],
                      12'($urandom)};
                do_lookup(va, 1'($urandom), 1'($urandom), "R1");
            end else if (op < 88) begin
                do_load(int'($urandom % N), 1'($urandom), pool[$urandom % 6],
                        20'($urandom), ($urandom % 4) != 0, 1'($urandom),
                        1'($urandom), 0, tgt);
            end else if (op < 97) begin
                do_inval(int'($urandom % N), 0);
            end else begin
                do_inval(0, 1);
            end
            check_entry(int'($urandom % N), "R6");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule